// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This controller sits beside an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). Each stage reports its own fault: an instruction address fault in fetch, an illegal opcode in decode, an arithmetic overflow in execute and a data address fault in memory. The controller does not act on a fault when it is detected. It stores the fault in a small record that moves down the pipe with the instruction. The only point where a decision is made is the memory stage.

When the instruction in the memory stage carries a fault, or an external interrupt request is present, the controller takes the exception. In that same cycle it kills every in-flight stage. On the next edge it writes a cause code and the faulting PC, blocks the faulting instruction from writing back, and redirects fetch to a fixed handler address. If one instruction has faults from several stages, the fault from the earliest stage is reported. An interrupt outranks every synchronous fault.

Top module: `pipe_exc_commit`

## Requirements
- R1: After reset, take, all kill outputs, wb_suppress and redirect are 0, and cause and epc read 0.
- R2: A fault reported in fetch, decode or execute does not raise take until its instruction reaches the memory stage. That is three cycles after the instruction is presented at fetch.
- R3: When one instruction has several faults, cause records the earliest stage's code: fetch address fault 1, illegal opcode 2, overflow 3, data address fault 4.
- R4: An interrupt request while the memory stage holds a valid instruction raises take with cause code 8, whatever faults that instruction carries.
- R5: In the take cycle, kill_f, kill_d, kill_x and kill_m are all 1. No instruction that was in flight at that moment raises take later.
- R6: In the cycle after take, epc holds the PC of the committing instruction and cause holds its code. Without take, neither register changes.
- R7: wb_suppress is 1 for exactly the one cycle after take.
- R8: redirect is 1 for exactly the one cycle after take, and redirect_pc then equals HANDLER_PC (default 0x80).
- R9: Fault inputs and the interrupt request have no effect while the matching stage holds no valid instruction.
- R10: A valid instruction with no fault and no interrupt passes through the pipe without raising take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PCW | PC of the fetched instruction |
| f_pc_fault | input | 1 | Instruction address fault in fetch |
| d_illegal | input | 1 | Illegal opcode found in decode |
| x_ovf | input | 1 | Arithmetic overflow in execute |
| m_daddr_fault | input | 1 | Data address fault in memory |
| irq | input | 1 | External interrupt request |
| take | output | 1 | Exception taken at the commit point this cycle |
| kill_f | output | 1 | Kill fetch stage |
| kill_d | output | 1 | Kill decode stage |
| kill_x | output | 1 | Kill execute stage |
| kill_m | output | 1 | Kill memory stage |
| wb_suppress | output | 1 | Block writeback of the faulting instruction |
| redirect | output | 1 | Force fetch to the handler |
| redirect_pc | output | PCW | Handler address |
| cause | output | CW | Cause code register |
| epc | output | PCW | Exception PC register |

## Verification
The assertions check on every cycle what follows a take: redirect and wb_suppress each pulse for one cycle, epc captures the committing PC, an interrupt writes code 8, and cause and epc stay unchanged when no exception is taken. Only the bench scenarios can show the other properties. These are the priority among faults in all 32 combinations of the four faults and the interrupt, the three-cycle delay from a fetch fault to the commit point, the silencing of younger faulting instructions after a kill, and the fact that faults on bubbles are ignored.

// File: rtl/pipe_exc_commit.sv
module pipe_exc_commit #(
  parameter int PCW = 32,
  parameter int CW  = 4,
  parameter logic [PCW-1:0] HANDLER_PC = 'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           f_valid,
  input  logic [PCW-1:0] f_pc,
  input  logic           f_pc_fault,
  input  logic           d_illegal,
  input  logic           x_ovf,
  input  logic           m_daddr_fault,
  input  logic           irq,
  output logic           take,
  output logic           kill_f,
  output logic           kill_d,
  output logic           kill_x,
  output logic           kill_m,
  output logic           wb_suppress,
  output logic           redirect,
  output logic [PCW-1:0] redirect_pc,
  output logic [CW-1:0]  cause,
  output logic [PCW-1:0] epc
);
  localparam logic [CW-1:0] C_IFAULT = CW'(1);
  localparam logic [CW-1:0] C_ILL    = CW'(2);
  localparam logic [CW-1:0] C_OVF    = CW'(3);
  localparam logic [CW-1:0] C_DFAULT = CW'(4);
  localparam logic [CW-1:0] C_IRQ    = CW'(8);

  logic           d_v, x_v, m_v;
  logic           d_exc, x_exc, m_exc;
  logic [CW-1:0]  d_code, x_code, m_code;
  logic [PCW-1:0] d_pc, x_pc, m_pc;
  logic [CW-1:0]  take_code;

  assign take      = m_v & (irq | m_exc | m_daddr_fault);
  assign take_code = irq ? C_IRQ : (m_exc ? m_code : C_DFAULT);

  assign kill_f = take;
  assign kill_d = take;
  assign kill_x = take;
  assign kill_m = take;
  assign redirect_pc = HANDLER_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_v <= 1'b0; x_v <= 1'b0; m_v <= 1'b0;
      d_exc <= 1'b0; x_exc <= 1'b0; m_exc <= 1'b0;
      d_code <= '0; x_code <= '0; m_code <= '0;
      d_pc <= '0; x_pc <= '0; m_pc <= '0;
      cause <= '0; epc <= '0;
      wb_suppress <= 1'b0; redirect <= 1'b0;
    end else begin
      d_v    <= f_valid & ~take;
      d_pc   <= f_pc;
      d_exc  <= f_valid & f_pc_fault;
      d_code <= C_IFAULT;

      x_v    <= d_v & ~take;
      x_pc   <= d_pc;
      x_exc  <= d_v & (d_exc | d_illegal);
      x_code <= d_exc ? d_code : C_ILL;

      m_v    <= x_v & ~take;
      m_pc   <= x_pc;
      m_exc  <= x_v & (x_exc | x_ovf);
      m_code <= x_exc ? x_code : C_OVF;

      wb_suppress <= take;
      redirect    <= take;
      if (take) begin
        cause <= take_code;
        epc   <= m_pc;
      end
    end
  end
endmodule

module pipe_exc_commit_chk #(
  parameter int PCW = 32,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           take,
  input logic           irq,
  input logic           redirect,
  input logic           wb_suppress,
  input logic [PCW-1:0] m_pc,
  input logic [PCW-1:0] epc,
  input logic [CW-1:0]  cause
);
  AST_REDIRECT_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) take |=> redirect); // R8
  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) redirect |=> !redirect); // R8
  AST_WB_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) take |=> wb_suppress); // R7
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wb_suppress |=> !wb_suppress); // R7
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) take |=> epc == $past(m_pc)); // R6
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !take |=> $stable(cause) && $stable(epc)); // R6
  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n) take && irq |=> cause == CW'(8)); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) take |=> !take); // R5
endmodule

bind pipe_exc_commit pipe_exc_commit_chk #(.PCW(PCW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .irq(irq), .redirect(redirect),
  .wb_suppress(wb_suppress), .m_pc(m_pc), .epc(epc), .cause(cause)
);

// File: tb/sim_pipe_exc_commit.sv
module sim_pipe_exc_commit;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 32;
  localparam int CW = 4;
  localparam logic [PCW-1:0] HPC = 32'h80;

  logic clk = 0, rst_n = 0;
  logic f_valid = 0, f_pc_fault = 0, d_illegal = 0, x_ovf = 0, m_daddr_fault = 0, irq = 0;
  logic [PCW-1:0] f_pc = '0;
  logic take, kill_f, kill_d, kill_x, kill_m, wb_suppress, redirect;
  logic [PCW-1:0] redirect_pc, epc;
  logic [CW-1:0] cause;
  int checks = 0, errors = 0;
  logic [CW-1:0] exp_cause = '0;
  logic [PCW-1:0] exp_epc = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_exc_commit #(.PCW(PCW), .CW(CW), .HANDLER_PC(HPC)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_regs(string req);
    chk(req, {31'b0, take}, 0);
    chk(req, {28'b0, cause}, {28'b0, exp_cause});
    chk(req, epc, exp_epc);
  endtask

  task automatic clr;
    f_valid = 0; f_pc_fault = 0; d_illegal = 0; x_ovf = 0; m_daddr_fault = 0; irq = 0;
  endtask

  task automatic run_one(logic [PCW-1:0] pc, logic pf, logic il, logic ov, logic da, logic iq);
    logic any;
    logic [CW-1:0] code;
    any = pf | il | ov | da | iq;
    code = iq ? 4'd8 : pf ? 4'd1 : il ? 4'd2 : ov ? 4'd3 : 4'd4;
    @(negedge clk); clr; f_valid = 1; f_pc = pc; f_pc_fault = pf; #1;
    chk("R2 take in fetch", {31'b0, take}, 0);
    @(negedge clk); clr; d_illegal = il; #1;
    chk("R2 take in decode", {31'b0, take}, 0);
    @(negedge clk); clr; x_ovf = ov; #1;
    chk("R2 take in execute", {31'b0, take}, 0);
    @(negedge clk); clr; m_daddr_fault = da; irq = iq; #1;
    chk(any ? "R2 take at commit" : "R10 no take", {31'b0, take}, {31'b0, any});
    chk("R5 kills", {28'b0, kill_f, kill_d, kill_x, kill_m}, any ? 32'hF : 32'h0);
    @(negedge clk); clr; #1;
    if (any) begin exp_cause = code; exp_epc = pc; end
    chk("R3 R4 R6 cause", {28'b0, cause}, {28'b0, exp_cause});
    chk("R6 epc", epc, exp_epc);
    chk("R7 wb_suppress", {31'b0, wb_suppress}, {31'b0, any});
    chk("R8 redirect", {31'b0, redirect}, {31'b0, any});
    if (any) chk("R8 redirect_pc", redirect_pc, HPC);
    chk("R5 no retake", {31'b0, take}, 0);
    @(negedge clk); #1;
    chk("R7 wb pulse", {31'b0, wb_suppress}, 0);
    chk("R8 redirect pulse", {31'b0, redirect}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 take", {31'b0, take}, 0);
    chk("R1 kills", {28'b0, kill_f, kill_d, kill_x, kill_m}, 0);
    chk("R1 wb", {31'b0, wb_suppress}, 0);
    chk("R1 redirect", {31'b0, redirect}, 0);
    chk("R1 cause", {28'b0, cause}, 0);
    chk("R1 epc", epc, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 32; i++)
      run_one(32'h1000 + 32'(i) * 4, i[0], i[1], i[2], i[3], i[4]);

    // R5: older data fault kills a younger fetch-faulting instruction
    @(negedge clk); clr; f_valid = 1; f_pc = 32'h2000;
    @(negedge clk); clr; f_valid = 1; f_pc = 32'h2004; f_pc_fault = 1;
    @(negedge clk); clr; f_valid = 1; f_pc = 32'h2008; d_illegal = 1;
    @(negedge clk); clr; m_daddr_fault = 1; x_ovf = 1; d_illegal = 1; #1;
    chk("R5 older take", {31'b0, take}, 1);
    @(negedge clk); clr; #1;
    exp_cause = 4'd4; exp_epc = 32'h2000;
    chk("R5 epc of older", epc, exp_epc);
    chk("R5 cause of older", {28'b0, cause}, {28'b0, exp_cause});
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); x_ovf = 1; m_daddr_fault = 1; #1;
      idle_regs("R5 killed younger silent");
    end

    // R9: faults and interrupt on bubbles
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); clr;
      f_pc_fault = k[0]; d_illegal = k[1]; x_ovf = k[2]; m_daddr_fault = k[3]; irq = 1; #1;
      idle_regs("R9 bubble faults");
    end
    @(negedge clk); clr;
    repeat (4) begin @(negedge clk); #1; idle_regs("R9 after bubbles"); end

    // R10: stream of clean instructions
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); clr; f_valid = 1; f_pc = 32'h3000 + 32'(k) * 4; #1;
      idle_regs("R10 clean stream");
    end
    @(negedge clk); clr;
    repeat (4) begin @(negedge clk); #1; idle_regs("R10 drain"); end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule